// File: doc/BRIEF.md
# Dual-Bank Gamma Code Register File

This block stores two complete sets of fourteen 8-bit gamma reference codes, one set per bank. In each set, channels 1 to 7 feed the upper gamma curve and channels 8 to 14 feed the lower curve. A simple write port carries a bank bit, a channel index and a data byte. In a full system a serial slave front end drives this port. A bank-select level picks which set reaches the fourteen registered code outputs, so the DACs downstream see one full code set swap for another on a single clock edge.

Firmware can therefore rewrite the idle bank while the active bank keeps driving the panel. After reset, all fourteen output enables stay low, which holds the analog buffers in high impedance. They rise only once both banks have each received at least two valid bytes, in any order. After that the enables stay high until the next reset.

Top module: `gamma_code_regfile`

## Requirements
- R1: After reset every stored code is zero, all fourteen code outputs read zero and every output enable is low.
- R2: A write with `wr_en` high, bank `wr_bank` (0 = bank A, 1 = bank B), index `wr_idx` in 1..14 and byte `wr_data` stores the byte unchanged. Bit 7 is the most significant bit, with weight 128. Channel k appears on `code_o[8k-1:8k-8]`. When the written bank is the selected one, the new code is visible after the second rising edge that follows the write cycle.
- R3: `bank_sel` low routes bank A to the outputs and high routes bank B. A change of `bank_sel` is synchronized through two flops and then registered, so all fourteen codes switch together on the third rising edge after the change and hold their old values before that edge.
- R4: A write to the bank that is not selected leaves every code output unchanged.
- R5: The output enables stay low until bank A and bank B have each taken at least two valid writes. Repeated writes to one channel count each time. All enables rise together on the second rising edge after the qualifying write.
- R6: Once high, the output enables stay high whatever is written or selected, until the next reset.
- R7: A write whose index is 0 or 15 changes no stored code and counts toward neither bank's write tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears codes, write tallies and the enable |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_bank | input | 1 | Target bank: 0 = A, 1 = B |
| wr_idx | input | 4 | Channel index, valid range 1..14 |
| wr_data | input | 8 | Code byte, bit 7 most significant |
| bank_sel | input | 1 | Asynchronous bank select: 0 = A, 1 = B |
| code_o | output | 112 | Fourteen registered codes, channel k at bits 8k-1..8k-8 |
| drive_en_o | output | 14 | Per-channel output enable, low = high impedance |

## Verification
The bench builds the block with its default parameters: seven channels per half, 8-bit codes, a saturation limit of two writes and a two-stage synchronizer. With these values the full 112-bit output word can be compared against a bench model after every step. The enable threshold is reached after a handful of writes, so early, late, one-sided and repeated-channel write orders can all be run before and after the enable rises. The three-edge bank-switch window is short enough to sample on every edge, and the index values 0 and 15 lie just outside the valid range, so the bench can probe both boundaries.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  // Widest index the helper functions accept; callers zero-extend into it.
  localparam int unsigned IDX_MAX_W = 8;

  // A channel index is legal when it lies in 1..nch.
  function automatic logic idx_valid(input logic [IDX_MAX_W-1:0] idx,
                                     input int unsigned nch);
    return (idx != '0) && (int'(idx) <= int'(nch));
  endfunction

  // Zero-based storage slot for a one-based channel index.
  function automatic int unsigned idx_slot(input logic [IDX_MAX_W-1:0] idx);
    return int'(idx) - 1;
  endfunction

  // Saturating increment of a write tally.
  function automatic int unsigned tally_next(input int unsigned cur,
                                             input int unsigned limit,
                                             input logic bump);
    if (bump && cur < limit) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gcr_bank.sv
module gcr_bank
  import gcr_pkg::*;
#(
  parameter int unsigned NCH     = 14,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned BANK_ID = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_bank,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [CODE_W-1:0]     wr_data,
  output logic [NCH*CODE_W-1:0] codes_o,
  output logic                  hit_o
);
  logic                 idx_ok;
  int unsigned          slot;

  assign idx_ok = idx_valid(IDX_MAX_W'(wr_idx), NCH);
  assign slot   = idx_slot(IDX_MAX_W'(wr_idx));
  // Accepted write to this bank: brought out for the tally and the checks.
  assign hit_o  = wr_en && (wr_bank == 1'(BANK_ID)) && idx_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              code_q <= '0;
      else if (hit_o && slot == c)             code_q <= wr_data;
    end
    assign codes_o[c*CODE_W +: CODE_W] = code_q;
  end

  // R4 / R7: contents move only after an accepted write to this bank.
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |=> $stable(codes_o));

endmodule

// File: rtl/gcr_enable.sv
module gcr_enable
  import gcr_pkg::*;
#(
  parameter int unsigned CNT_SAT = 2,
  localparam int unsigned CNT_W  = $clog2(CNT_SAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_a,
  input  logic hit_b,
  output logic en_o
);
  logic [CNT_W-1:0] tally_a_q, tally_b_q;
  logic             both_full;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_a_q <= '0;
      tally_b_q <= '0;
    end else begin
      tally_a_q <= CNT_W'(tally_next(int'(tally_a_q), CNT_SAT, hit_a));
      tally_b_q <= CNT_W'(tally_next(int'(tally_b_q), CNT_SAT, hit_b));
    end
  end

  assign both_full = (int'(tally_a_q) >= CNT_SAT) && (int'(tally_b_q) >= CNT_SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_q | both_full;
  end

  assign en_o = en_q;

  assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !both_full) |=> !en_q);

  assert_tally_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tally_a_q) <= CNT_SAT) && (int'(tally_b_q) <= CNT_SAT));

  // R7: a tally never moves without an accepted write.
  assert_tally_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b) |=> ($stable(tally_a_q) && $stable(tally_b_q)));

endmodule

// File: rtl/gamma_code_regfile.sv
module gamma_code_regfile #(
  parameter int unsigned HALF_CH     = 7,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned WR_SAT      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NCH        = 2 * HALF_CH,
  localparam int unsigned IDX_W      = $clog2(NCH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_bank,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [CODE_W-1:0]     wr_data,
  input  logic                  bank_sel,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        drive_en_o
);
  logic                  sel_s;
  logic [NCH*CODE_W-1:0] bank_codes [2];
  logic [1:0]            bank_hit;
  logic                  en;
  logic [NCH*CODE_W-1:0] code_q;

  gcr_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bank_sel), .q_o(sel_s)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gcr_bank #(
      .NCH(NCH), .CODE_W(CODE_W), .IDX_W(IDX_W), .BANK_ID(b)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
      .codes_o(bank_codes[b]), .hit_o(bank_hit[b])
    );
  end

  gcr_enable #(.CNT_SAT(WR_SAT)) u_enable (
    .clk(clk), .rst_n(rst_n),
    .hit_a(bank_hit[0]), .hit_b(bank_hit[1]), .en_o(en)
  );

  // One register stage so that every channel swaps on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= bank_codes[sel_s];
  end

  assign code_o     = code_q;
  assign drive_en_o = {NCH{en}};

  // R3: with selection steady and no write, the presented set holds.
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s == $past(sel_s) && !$past(wr_en)) |=> $stable(code_q));

  // R4: a write to the idle bank under a steady selection leaves outputs alone.
  assert_idle_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit[~sel_s] && !bank_hit[sel_s] && sel_s == $past(sel_s) && !$past(wr_en))
      |=> $stable(code_q));

  // R1 / R5: enables are all equal at all times.
  assert_enable_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o == '0) || (drive_en_o == '1));

endmodule

// File: tb/tb_gamma_code_regfile.sv
module tb_gamma_code_regfile;
  localparam int NC = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_bank = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [7:0]    wr_data = '0;
  logic          bank_sel = 1'b0;
  logic [111:0]  code_o;
  logic [13:0]   drive_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] mA [1:NC];
  logic [7:0] mB [1:NC];

  // {bank, index, data}
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 4'd2,  8'h10}, {1'b0, 4'd7,  8'hFE}, {1'b0, 4'd8,  8'h00},
    {1'b1, 4'd4,  8'h3C}, {1'b0, 4'd13, 8'h81}, {1'b1, 4'd9,  8'h7F},
    {1'b0, 4'd0,  8'hEE}, {1'b1, 4'd14, 8'hC3}, {1'b0, 4'd15, 8'h44},
    {1'b0, 4'd2,  8'h20}
  };

  gamma_code_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_idx(wr_idx), .wr_data(wr_data), .bank_sel(bank_sel),
    .code_o(code_o), .drive_en_o(drive_en_o)
  );

  always #10 clk = ~clk;

  function automatic logic [111:0] pack_model(input logic b);
    logic [111:0] v = '0;
    for (int k = 1; k <= NC; k++) v[(k-1)*8 +: 8] = b ? mB[k] : mA[k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [111:0] act, input logic [111:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic b, input logic [3:0] i, input logic [7:0] d);
    wr_en = 1'b1; wr_bank = b; wr_idx = i; wr_data = d;
    if (i >= 1 && i <= NC) begin
      if (b) mB[i] = d; else mA[i] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int k = 1; k <= NC; k++) begin mA[k] = '0; mB[k] = '0; end
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 codes", code_o, '0);
    chk("R1 enables", 112'(drive_en_o), '0);

    // R2: selected bank A write, visible after the second edge
    wr(1'b0, 4'd1, 8'h9C);
    step(1);
    chk("R2 ch1 value", 112'(code_o[7:0]), 112'(8'h9C));
    chk("R2 msb first", 112'(code_o[7]), 112'(1'b1));
    wr(1'b0, 4'd14, 8'h01);
    wr(1'b1, 4'd3, 8'h55);
    // R7: out-of-range indices count for nothing
    wr(1'b1, 4'd0, 8'hFF);
    wr(1'b1, 4'd15, 8'hFF);
    step(2);
    chk("R5 R7 enable still low", 112'(drive_en_o), '0);
    bank_sel = 1'b1;
    step(3);
    chk("R7 bank B untouched by bad index", code_o, pack_model(1'b1));

    // R5: second valid B write opens the enables two edges later
    wr(1'b1, 4'd10, 8'hA7);
    chk("R5 enable not yet", 112'(drive_en_o), '0);
    step(1);
    chk("R5 enable high", 112'(drive_en_o), 112'(14'h3FFF));
    chk("R2 ch10 lower group", 112'(code_o[79:72]), 112'(8'hA7));

    bank_sel = 1'b0;
    step(3);
    chk("R3 bank A shown", code_o, pack_model(1'b0));

    // Vector table with bank A selected
    foreach (VEC[v]) begin
      wr(VEC[v][12], VEC[v][11:8], VEC[v][7:0]);
      step(1);
      chk(VEC[v][12] ? "R4 idle bank write" : "R2 R7 table write", code_o, pack_model(1'b0));
    end

    // R3: switch lands on the third edge, all channels together
    bank_sel = 1'b1;
    step(1);
    chk("R3 edge1 old set", code_o, pack_model(1'b0));
    step(1);
    chk("R3 edge2 old set", code_o, pack_model(1'b0));
    step(1);
    chk("R3 edge3 new set", code_o, pack_model(1'b1));

    // R4: writes to idle bank A while B drives
    wr(1'b0, 4'd7, 8'h11);
    chk("R4 idle write c0", code_o, pack_model(1'b1));
    wr(1'b0, 4'd7, 8'h22);
    chk("R4 idle write c1", code_o, pack_model(1'b1));
    step(2);
    chk("R4 idle write c3", code_o, pack_model(1'b1));

    // R2 boundaries: top and bottom channel of bank B
    wr(1'b1, 4'd14, 8'hFF);
    wr(1'b1, 4'd1, 8'h80);
    step(1);
    chk("R2 ch14", 112'(code_o[111:104]), 112'(8'hFF));
    chk("R2 ch1 weight 128", 112'(code_o[7:0]), 112'(8'h80));
    chk("R6 enable held", 112'(drive_en_o), 112'(14'h3FFF));

    // R6 / R1: reset clears everything
    do_reset();
    chk("R1 R6 enable cleared", 112'(drive_en_o), '0);
    chk("R1 codes cleared", code_o, '0);

    // R5: one-sided writes saturate and do not open the enables
    bank_sel = 1'b0;
    for (int i = 0; i < 5; i++) wr(1'b0, 4'd2, 8'(i + 1));
    step(2);
    chk("R5 bank A only", 112'(drive_en_o), '0);
    wr(1'b1, 4'd2, 8'h33);
    step(2);
    chk("R5 one B write", 112'(drive_en_o), '0);
    wr(1'b1, 4'd2, 8'h34);
    step(1);
    chk("R5 both banks two", 112'(drive_en_o), 112'(14'h3FFF));
    chk("R2 repeated channel last wins", code_o, pack_model(1'b0));

    finish_run();
  end
endmodule